// File: doc/BRIEF.md
# Alternating Valley Selection Sequencer

This block sits beside the timing logic of a quasi-resonant flyback controller. For every switching cycle it decides whether the power switch turns on at the first or at the second resonant valley after the blanking interval. Moving between the two spreads the switching frequency and lowers conducted EMI. The alternating pattern runs only while the converter has a high input voltage and a short on-time. In every other case the first valley is used.

A counter of gate pulses runs freely, whatever the other inputs do. It defines a repeating pattern of two first-valley cycles followed by two second-valley cycles. At each turn-off the block samples the measured on-time and the feedback comparator flag. That sample decides whether the pattern applies to the next cycle. Valley strobes and the detection-window expiry come from the surrounding timer. The block answers with a one-cycle turn-on request. Blanking and window timing, and the gate driver itself, are outside this block.

Top module: `avs_valley_seq`

## Requirements
- R1: Reset has the following effects:
  - `valley_idx` is 0, meaning the first valley.
  - `turn_on_req` is low.
  - The pulse counter is cleared.
  - The alternating mode is disarmed.
  - The first two gate pulses after reset therefore select valley 0.
- R2: Arming at turn-off works as follows:
  - When `off_stb` is high, the mode becomes armed if `fb_high` is 1 and `on_time` is below `ON_LIMIT` (default 500 clocks).
  - Otherwise the mode becomes disarmed. An on-time equal to `ON_LIMIT` disarms.
  - The new arming state first affects the next gate pulse.
- R3: The pulse counter advances by one on every `gate_stb`, modulo 2*`GROUP`, independent of all other inputs.
- R4: While armed, a gate pulse samples the counter value as it was before that pulse. It sets `valley_idx` to 1 (second valley) when that value is at least `GROUP`, and to 0 otherwise. With `GROUP`=2 this yields the pattern 0,0,1,1.
- R5: While disarmed, every gate pulse sets `valley_idx` to 0.
- R6: `valley_idx` changes only on the clock edge that follows a `gate_stb`.
- R7: With `valley_idx`=0, the first `valley_stb` after a gate pulse raises `turn_on_req` for one cycle, on the following clock edge.
- R8: With `valley_idx`=1, the first `valley_stb` is counted but gives no request. The second `valley_stb` raises `turn_on_req`.
- R9: A `win_exp` pulse in a cycle that has not yet requested raises `turn_on_req`. It has priority over a coincident `valley_stb`, and only one request results.
- R10: At most one request is produced between two gate pulses. Later valley strobes and expiries are ignored.
- R11: A `valley_stb` in the same cycle as `gate_stb` is ignored and does not count as a valley of the new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_stb | input | 1 | One-cycle strobe at each gate turn-on |
| off_stb | input | 1 | One-cycle strobe at each gate turn-off |
| on_time | input | ON_W | Measured on-time of the pulse ending at `off_stb`, in clocks |
| fb_high | input | 1 | Feedback is above the trigger level |
| valley_stb | input | 1 | Valley detected (after blanking) |
| win_exp | input | 1 | Detection window expired |
| valley_idx | output | 1 | Selected valley for the current cycle: 0 first, 1 second |
| turn_on_req | output | 1 | One-cycle turn-on request |

## Verification
The forced turn-on and the selected-valley turn-on can both become due in the same cycle. The bench provokes this during a second-valley cycle by driving `win_exp` and the first `valley_stb` in one cycle. It expects exactly one request on the next edge and no request from the valley strobe that follows. A second collision drives a valley strobe together with `gate_stb`. It is judged by the absence of a request, followed by a request on the next lone valley.

// File: rtl/avs_pkg.sv
package avs_pkg;
  typedef enum logic {
    VAL_FIRST  = 1'b0,
    VAL_SECOND = 1'b1
  } valley_e;
endpackage

// File: rtl/avs_pair_counter.sv
module avs_pair_counter #(
  parameter int GROUP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_stb,
  output logic second_half
);
  localparam int PERIOD = 2 * GROUP;
  localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HALF = CW'(GROUP);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  generate
    if ((PERIOD & (PERIOD - 1)) == 0) begin : g_pow2
      assign cnt_nx = cnt + 1'b1;
    end else begin : g_wrap
      assign cnt_nx = (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (gate_stb) cnt <= cnt_nx;
  end

  assign second_half = (cnt >= HALF);

  AST_PAIR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    gate_stb |=> cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + 1'b1)); // R3
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !gate_stb |=> $stable(cnt)); // R3
endmodule

// File: rtl/avs_arm_ctrl.sv
module avs_arm_ctrl #(
  parameter int ON_W     = 10,
  parameter int ON_LIMIT = 500
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            off_stb,
  input  logic            fb_high,
  input  logic [ON_W-1:0] on_time,
  output logic            armed
);
  localparam logic [ON_W-1:0] LIM = ON_W'(ON_LIMIT);

  logic short_on;
  assign short_on = (on_time < LIM);

  always_ff @(posedge clk) begin
    if (rst)          armed <= 1'b0;
    else if (off_stb) armed <= fb_high & short_on;
  end

  AST_ARM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !off_stb |=> $stable(armed)); // R2
  AST_ARM_LONG: assert property (@(posedge clk) disable iff (rst)
    (off_stb && on_time >= LIM) |=> !armed); // R2
  AST_ARM_FBLOW: assert property (@(posedge clk) disable iff (rst)
    (off_stb && !fb_high) |=> !armed); // R2
endmodule

// File: rtl/avs_valley_pick.sv
module avs_valley_pick (
  input  logic clk,
  input  logic rst,
  input  logic gate_stb,
  input  logic sel_second,
  input  logic valley_stb,
  input  logic win_exp,
  output logic turn_on_req
);
  logic seen;
  logic done;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen        <= 1'b0;
      done        <= 1'b0;
      turn_on_req <= 1'b0;
    end else begin
      turn_on_req <= 1'b0;
      if (gate_stb) begin
        seen <= 1'b0;
        done <= 1'b0;
      end else if (!done) begin
        if (win_exp) begin
          turn_on_req <= 1'b1;
          done        <= 1'b1;
        end else if (valley_stb) begin
          if (!sel_second || seen) begin
            turn_on_req <= 1'b1;
            done        <= 1'b1;
          end else begin
            seen <= 1'b1;
          end
        end
      end
    end
  end

  AST_FORCE_WINS: assert property (@(posedge clk) disable iff (rst)
    (win_exp && !gate_stb && !done) |=> turn_on_req); // R9
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    turn_on_req |=> !turn_on_req); // R10
  AST_SECOND_SKIPS: assert property (@(posedge clk) disable iff (rst)
    (valley_stb && sel_second && !seen && !done && !gate_stb && !win_exp) |=> !turn_on_req); // R8
  AST_GATE_MASKS: assert property (@(posedge clk) disable iff (rst)
    gate_stb |=> !turn_on_req); // R11
endmodule

// File: rtl/avs_valley_seq.sv
module avs_valley_seq
  import avs_pkg::*;
#(
  parameter int ON_W     = 10,
  parameter int ON_LIMIT = 500,
  parameter int GROUP    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gate_stb,
  input  logic            off_stb,
  input  logic [ON_W-1:0] on_time,
  input  logic            fb_high,
  input  logic            valley_stb,
  input  logic            win_exp,
  output logic            valley_idx,
  output logic            turn_on_req
);
  logic    armed;
  logic    second_half;
  valley_e sel_q;

  avs_pair_counter #(.GROUP(GROUP)) u_pair (
    .clk(clk), .rst(rst), .gate_stb(gate_stb), .second_half(second_half)
  );

  avs_arm_ctrl #(.ON_W(ON_W), .ON_LIMIT(ON_LIMIT)) u_arm (
    .clk(clk), .rst(rst), .off_stb(off_stb), .fb_high(fb_high),
    .on_time(on_time), .armed(armed)
  );

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= VAL_FIRST;
    else if (gate_stb)
      sel_q <= (armed && second_half) ? VAL_SECOND : VAL_FIRST;
  end

  assign valley_idx = sel_q;

  avs_valley_pick u_pick (
    .clk(clk), .rst(rst), .gate_stb(gate_stb),
    .sel_second(sel_q == VAL_SECOND), .valley_stb(valley_stb),
    .win_exp(win_exp), .turn_on_req(turn_on_req)
  );

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !gate_stb |=> $stable(valley_idx)); // R6
  AST_IDLE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (gate_stb && !armed) |=> valley_idx == VAL_FIRST); // R5
  AST_ARMED_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (gate_stb && armed) |=> valley_idx == $past(second_half)); // R4
endmodule

// File: tb/tb_avs_valley_seq.sv
module tb_avs_valley_seq;
  localparam int ON_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gate_stb = 1'b0, off_stb = 1'b0, fb_high = 1'b0;
  logic valley_stb = 1'b0, win_exp = 1'b0;
  logic [ON_W-1:0] on_time = '0;
  logic valley_idx, turn_on_req;
  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  avs_valley_seq #(.ON_W(ON_W), .ON_LIMIT(500), .GROUP(2)) dut (
    .clk(clk), .rst(rst), .gate_stb(gate_stb), .off_stb(off_stb),
    .on_time(on_time), .fb_high(fb_high), .valley_stb(valley_stb),
    .win_exp(win_exp), .valley_idx(valley_idx), .turn_on_req(turn_on_req)
  );

  // fb/ton arm the NEXT cycle; idx/valleys/reqat belong to this cycle.
  // reqat: 0 none, 1/2 on that valley, 3 on window expiry
  typedef struct packed {
    logic            fb;
    logic [ON_W-1:0] ton;
    logic [1:0]      nval;
    logic            expw;
    logic            idx;
    logic [1:0]      reqat;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 10'd100, 2'd2, 1'b0, 1'b0, 2'd1},
    '{1'b1, 10'd100, 2'd1, 1'b0, 1'b0, 2'd1},
    '{1'b1, 10'd100, 2'd2, 1'b0, 1'b1, 2'd2},
    '{1'b0, 10'd100, 2'd1, 1'b1, 1'b1, 2'd3},
    '{1'b1, 10'd600, 2'd0, 1'b1, 1'b0, 2'd3},
    '{1'b1, 10'd499, 2'd1, 1'b0, 1'b0, 2'd1},
    '{1'b1, 10'd500, 2'd3, 1'b0, 1'b1, 2'd2},
    '{1'b1, 10'd0,   2'd0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 10'd100, 2'd1, 1'b1, 1'b0, 2'd1},
    '{1'b1, 10'd100, 2'd1, 1'b0, 1'b0, 2'd1},
    '{1'b1, 10'd100, 2'd1, 1'b0, 1'b1, 2'd0},
    '{1'b1, 10'd100, 2'd2, 1'b0, 1'b1, 2'd2}
  };

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic do_gate(input bit with_valley);
    @(negedge clk); gate_stb = 1'b1; valley_stb = with_valley;
    @(negedge clk); gate_stb = 1'b0; valley_stb = 1'b0;
  endtask

  task automatic do_off(input bit fb, input logic [ON_W-1:0] t);
    @(negedge clk); off_stb = 1'b1; fb_high = fb; on_time = t;
    @(negedge clk); off_stb = 1'b0;
  endtask

  task automatic do_valley(input bit v, input bit w);
    @(negedge clk); valley_stb = v; win_exp = w;
    @(negedge clk); valley_stb = 1'b0; win_exp = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset idx", valley_idx, 0);
    chk("R1 reset req", turn_on_req, 0);

    // table: R2 arming, R3 counter, R4/R5 selection, R7-R10 requests
    for (int i = 0; i < 12; i++) begin
      do_gate(1'b0);
      chk($sformatf("R2 R3 R4 R5 vec%0d idx", i), valley_idx, VEC[i].idx);
      do_off(VEC[i].fb, VEC[i].ton);
      chk($sformatf("R6 vec%0d idx after off", i), valley_idx, VEC[i].idx);
      for (int j = 1; j <= VEC[i].nval; j++) begin
        do_valley(1'b1, 1'b0);
        chk($sformatf("R7 R8 R10 vec%0d valley%0d req", i, j),
            turn_on_req, (VEC[i].reqat == 2'(j)) ? 1 : 0);
      end
      if (VEC[i].expw) begin
        do_valley(1'b0, 1'b1);
        chk($sformatf("R9 R10 vec%0d expiry req", i),
            turn_on_req, (VEC[i].reqat == 2'd3) ? 1 : 0);
      end
    end

    // R11: valley together with gate pulse is ignored (pulse 12, idx 0)
    do_gate(1'b1);
    chk("R11 gate+valley req", turn_on_req, 0);
    chk("R4 pulse12 idx", valley_idx, 0);
    do_off(1'b1, 10'd100);
    do_valley(1'b1, 1'b0);
    chk("R11 next valley req", turn_on_req, 1);

    do_gate(1'b0);
    chk("R4 pulse13 idx", valley_idx, 0);
    do_off(1'b1, 10'd100);
    do_valley(1'b1, 1'b0);
    chk("R7 pulse13 req", turn_on_req, 1);

    // R9: expiry and first valley together in a second-valley cycle
    do_gate(1'b0);
    chk("R4 pulse14 idx", valley_idx, 1);
    do_off(1'b1, 10'd100);
    do_valley(1'b1, 1'b1);
    chk("R9 coincident req", turn_on_req, 1);
    do_valley(1'b1, 1'b0);
    chk("R10 later valley req", turn_on_req, 0);

    // R1: mid-run reset clears counter and arming
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 rerst idx", valley_idx, 0);
    chk("R1 rerst req", turn_on_req, 0);
    do_gate(1'b0);
    chk("R1 disarmed idx", valley_idx, 0);
    do_off(1'b1, 10'd50);
    do_gate(1'b0);
    chk("R1 R3 pulse1 idx", valley_idx, 0);
    do_gate(1'b0);
    chk("R1 R3 pulse2 idx", valley_idx, 1);

    finish_run();
  end
endmodule